// File: doc/BRIEF.md
# Code Block CRC24 Attacher

This block sits in front of a channel encoder and turns a byte stream of code block payload into a complete code block of K bits. The payload arrives eight bits per beat on a valid/ready interface with start and end markers. A size index, sampled on the first beat, selects K. In checking mode the block takes K/8-3 payload bytes, folds each byte into a 24-bit CRC register in a single cycle, and then emits the three parity bytes. In bypass mode it forwards K/8 bytes untouched.

Both stream sides follow valid/ready rules. A beat moves when valid and ready are both high at a rising clock edge. The output stage is one register. The block raises `in_ready` only while `out_ready` is high and no parity byte is waiting to be emitted. So input back-pressure follows output back-pressure in the same cycle, and no beat is ever dropped or duplicated. A held output beat keeps its data and markers until it is taken.

Top module: `cbc_crc_attach`

## Requirements
- R1: After reset `out_valid` is low and stays low until a beat with `in_sop` high is accepted.
- R2: Bit j of input byte n is code block bit 8n+j. The CRC uses generator D^24+D^23+D^6+D^5+D+1 and starts from zero. Parity bit p0 is the coefficient of D^23 of the remainder. Parity bit p(8m+i) goes out in bit i of the m-th parity byte, so p0 is in bit 0 of the first parity byte.
- R3: With `crc_en` high on the first beat, the block accepts K/8-3 payload bytes, echoes them in order, and appends 3 parity bytes, for K/8 output bytes in total.
- R4: With `crc_en` low on the first beat, the block accepts K/8 bytes and outputs exactly those bytes, with no parity added.
- R5: K follows from the size index i. For 1..60, K=32+8i. For 61..92, K=512+16(i-60). For 93..124, K=1024+32(i-92). For 125..188, K=2048+64(i-124).
- R6: An index of 0 or above 188 selects K=40.
- R7: `size_idx` and `crc_en` are sampled only on the accepted start beat. Their values on later beats have no effect on the packet.
- R8: `in_ready` is low whenever `out_ready` is low, and while parity bytes are still to be loaded. Otherwise it equals `out_ready`.
- R9: While `out_valid` is high and `out_ready` is low, the output beat stays unchanged. Every accepted payload beat appears exactly once.
- R10: A byte accepted at a clock edge appears on the output after that same edge, with one register of latency.
- R11: An accepted beat with `in_eop` high ends the payload early. The parity (in checking mode) is computed over the bytes received so far.
- R12: While idle, accepted beats without `in_sop` are discarded and produce no output.
- R13: `out_sop` marks the first output byte of a block. `out_eop` marks the last output byte: the third parity byte in checking mode, or the last payload byte in bypass mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | 8 | Payload byte, bit 0 first in bit order |
| in_sop | input | 1 | First beat of a code block |
| in_eop | input | 1 | Last payload beat (optional early end) |
| size_idx | input | 8 | Block size index, sampled with the start beat |
| crc_en | input | 1 | 1 = attach CRC, 0 = bypass; sampled with the start beat |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer can take an output beat |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First output byte of a block |
| out_eop | output | 1 | Last output byte of a block |

## Verification
Two functions can fall on the same edge. The third parity byte of one block can leave the output register on the edge that accepts the start beat of the next block. Also, back-pressure can arrive while the parity bytes are being loaded. The bench provokes both by queuing blocks back to back and by switching to random `out_ready` and random input gaps. A behavioural model tracks the pending bytes and judges every cycle. It checks that `out_valid` matches a non-empty expectation, that the front byte and its markers match, and that `in_ready` is low exactly while two or more parity bytes are still outstanding or `out_ready` is low.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int CRC_W = 24;
  localparam logic [CRC_W-1:0] CRC_POLY = 24'h800063;

  typedef enum logic [1:0] {PH_IDLE, PH_DATA, PH_CRC} phase_e;

  // Fold one byte, bit 0 first, into the CRC register.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c_in,
                                                input logic [7:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = d[i] ^ c[CRC_W-1];
      c = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return c;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction
endpackage

// File: rtl/cbc_size_map.sv
module cbc_size_map #(
  parameter int IDX_W = 8,
  parameter int KB_W  = 10
) (
  input  logic [IDX_W-1:0] idx,
  output logic [KB_W-1:0]  kbytes
);
  localparam int IDX_MAX = 188;

  // Code block length in bytes, piecewise linear in the index.
  always_comb begin
    int i;
    int v;
    i = int'(idx);
    if (i < 1 || i > IDX_MAX) i = 1;
    if (i <= 60)       v = 4 + i;
    else if (i <= 92)  v = 64 + 2 * (i - 60);
    else if (i <= 124) v = 128 + 4 * (i - 92);
    else               v = 256 + 8 * (i - 124);
    kbytes = KB_W'(v);
  end
endmodule

// File: rtl/cbc_crc_engine.sv
module cbc_crc_engine
  import cbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             upd,
  input  logic [7:0]       din,
  output logic [CRC_W-1:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n)     crc <= '0;
    else if (start) crc <= crc_step('0, din);
    else if (upd)   crc <= crc_step(crc, din);
  end
endmodule

// File: rtl/cbc_crc_attach.sv
module cbc_crc_attach
  import cbc_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int KB_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [IDX_W-1:0] size_idx,
  input  logic             crc_en,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_eop
);
  localparam int          PAR_BYTES = CRC_W / 8;
  localparam logic [KB_W-1:0] KB_MIN = KB_W'(5);
  localparam logic [KB_W-1:0] KB_MAX = KB_W'(768);

  phase_e           state;
  logic [KB_W-1:0]  cnt, lim_q, kb_in, lim_next;
  logic             en_q;
  logic [1:0]       sel;
  logic [CRC_W-1:0] crc;
  logic [7:0]       par_byte;
  logic             acc, take, last_data, en_cur;
  logic             nv, ns, ne;
  logic [7:0]       nd;

  cbc_size_map #(.IDX_W(IDX_W), .KB_W(KB_W)) u_map (
    .idx(size_idx), .kbytes(kb_in)
  );

  cbc_crc_engine u_crc (
    .clk(clk), .rst_n(rst_n),
    .start(acc && state == PH_IDLE && in_sop),
    .upd(acc && state == PH_DATA),
    .din(in_data), .crc(crc)
  );

  assign in_ready  = out_ready && (state != PH_CRC);
  assign acc       = in_valid && in_ready;
  assign take      = acc && (state == PH_DATA || in_sop);
  assign lim_next  = crc_en ? kb_in - KB_W'(PAR_BYTES) : kb_in;
  assign en_cur    = (state == PH_IDLE) ? crc_en : en_q;
  assign last_data = (state == PH_IDLE) ? in_eop
                                        : ((cnt + KB_W'(1) == lim_q) || in_eop);

  always_comb begin
    case (sel)
      2'd0:    par_byte = rev8(crc[23:16]);
      2'd1:    par_byte = rev8(crc[15:8]);
      default: par_byte = rev8(crc[7:0]);
    endcase
  end

  always_comb begin
    nv = take || (state == PH_CRC);
    nd = (state == PH_CRC) ? par_byte : in_data;
    ns = take && (state == PH_IDLE);
    ne = (state == PH_CRC) ? (sel == 2'(PAR_BYTES - 1))
                           : (take && last_data && !en_cur);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PH_IDLE;
      cnt   <= '0;
      lim_q <= '0;
      en_q  <= 1'b0;
      sel   <= '0;
    end else begin
      case (state)
        PH_IDLE: if (acc && in_sop) begin
          en_q  <= crc_en;
          lim_q <= lim_next;
          cnt   <= KB_W'(1);
          sel   <= '0;
          if (in_eop) state <= crc_en ? PH_CRC : PH_IDLE;
          else        state <= PH_DATA;
        end
        PH_DATA: if (acc) begin
          cnt <= cnt + KB_W'(1);
          sel <= '0;
          if (last_data) state <= en_q ? PH_CRC : PH_IDLE;
        end
        PH_CRC: if (out_ready) begin
          sel <= sel + 2'd1;
          if (sel == 2'(PAR_BYTES - 1)) state <= PH_IDLE;
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
    end else if (out_ready) begin
      out_valid <= nv;
      out_data  <= nd;
      out_sop   <= ns;
      out_eop   <= ne;
    end
  end

  AST_BLOCK_IN_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    state == PH_CRC |-> !in_ready); // R8
  AST_IN_WAITS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> !in_ready); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_eop) && $stable(out_sop)); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    state == PH_DATA |-> cnt < lim_q); // R3
  AST_K_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_sop && state == PH_IDLE |-> kb_in >= KB_MIN && kb_in <= KB_MAX); // R5
  AST_CRC_ONLY_EN: assert property (@(posedge clk) disable iff (!rst_n)
    state == PH_CRC |-> en_q); // R4
endmodule

// File: tb/cbc_crc_attach_test.sv
module cbc_crc_attach_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct packed {logic [7:0] d; logic sop; logic eop; logic [7:0] idx; logic en;} beat_t;
  typedef struct packed {logic [7:0] d; logic sop; logic eop; logic par;} exp_t;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, in_sop = 0, in_eop = 0, crc_en = 0;
  logic [7:0] in_data = 0, size_idx = 0;
  logic out_valid, out_ready = 0, out_sop, out_eop;
  logic [7:0] out_data;

  cbc_crc_attach uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .size_idx(size_idx),
    .crc_en(crc_en), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  beat_t src_q[$];
  exp_t  exp_q[$];
  int checks = 0, errors = 0, cycles = 0;
  bit rnd_mode = 0;
  int m_phase = 0, m_cnt = 0, m_lim = 0;
  bit m_en = 0, m_first = 0;
  logic [23:0] m_crc = 0;

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, expv, cycles);
    end
  endtask

  function automatic int k_of(int idx);
    int i = idx;
    if (i < 1 || i > 188) i = 1;
    if (i <= 60)  return 32 + 8 * i;
    if (i <= 92)  return 512 + 16 * (i - 60);
    if (i <= 124) return 1024 + 32 * (i - 92);
    return 2048 + 64 * (i - 124);
  endfunction

  // Packet of nbytes beats; eop_at marks the beat carrying in_eop.
  task automatic add_pkt(int idx, bit en, int nbytes, int eop_at);
    for (int n = 0; n < nbytes; n++) begin
      beat_t b;
      b.d   = 8'($urandom);
      b.sop = (n == 0);
      b.eop = (n == eop_at);
      b.idx = (n == 0) ? 8'(idx) : 8'($urandom);  // R7: junk on later beats
      b.en  = (n == 0) ? en : 1'($urandom);
      src_q.push_back(b);
    end
  endtask

  task automatic model_accept(beat_t b);
    if (m_phase == 0) begin
      if (!b.sop) return;                          // R12
      m_en = b.en;
      m_lim = b.en ? k_of(int'(b.idx)) / 8 - 3 : k_of(int'(b.idx)) / 8;
      m_cnt = 0; m_crc = 0; m_first = 1; m_phase = 1;
    end
    begin
      bit last;
      exp_t e;
      for (int i = 0; i < 8; i++) begin
        bit fb = b.d[i] ^ m_crc[23];
        m_crc = {m_crc[22:0], 1'b0} ^ (fb ? 24'h800063 : 24'h0);
      end
      m_cnt++;
      last = (m_cnt == m_lim) || b.eop;            // R11
      e.d = b.d; e.sop = m_first; e.eop = last && !m_en; e.par = 0;
      exp_q.push_back(e);
      m_first = 0;
      if (last) begin
        m_phase = 0;
        if (m_en) begin
          for (int j = 0; j < 3; j++) begin
            exp_t p;
            for (int i = 0; i < 8; i++) p.d[i] = m_crc[23 - (8*j + i)];
            p.sop = 0; p.eop = (j == 2); p.par = 1;
            exp_q.push_back(p);
          end
        end
      end
    end
  endtask

  task automatic step();
    int pend;
    @(negedge clk);
    cycles++;
    if (src_q.size() > 0 && (!rnd_mode || ($urandom % 2) == 1)) begin
      in_valid = 1; in_data = src_q[0].d; in_sop = src_q[0].sop;
      in_eop = src_q[0].eop; size_idx = src_q[0].idx; crc_en = src_q[0].en;
    end else begin
      in_valid = 0; in_data = 8'($urandom); in_sop = 1'($urandom);
      in_eop = 0; size_idx = 8'($urandom); crc_en = 1'($urandom);
    end
    out_ready = !rnd_mode || (($urandom % 10) < 7);
    #1;
    pend = 0;
    foreach (exp_q[k]) if (exp_q[k].par) pend++;
    // R8: input ready rule
    if (!out_ready) check(!in_ready, "R8", in_ready, 0);
    else check(in_ready == (pend < 2), "R8", in_ready, pend < 2);
    // R10 / R9: output valid exactly when something is owed
    check(out_valid == (exp_q.size() > 0), "R10", out_valid, exp_q.size() > 0);
    if (out_valid && exp_q.size() > 0) begin
      check(out_data == exp_q[0].d, exp_q[0].par ? "R2" : "R3", out_data, exp_q[0].d);
      check({out_sop, out_eop} == {exp_q[0].sop, exp_q[0].eop}, "R13",
            {out_sop, out_eop}, {exp_q[0].sop, exp_q[0].eop});
    end
    if (out_valid && out_ready && exp_q.size() > 0) void'(exp_q.pop_front());
    if (in_valid && in_ready) begin
      model_accept(src_q[0]);
      void'(src_q.pop_front());
    end
  endtask

  task automatic drain();
    while ((src_q.size() > 0 || exp_q.size() > 0) && cycles < WATCHDOG) step();
    repeat (3) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1", out_valid, 0);
    rst_n = 1;
    repeat (2) step();
    check(out_valid == 0, "R1", out_valid, 0);

    // Phase A: no back-pressure, no gaps
    add_pkt(1, 1, 2, 1);        // R3: K=40, 2 payload + 3 parity
    add_pkt(1, 0, 5, 4);        // R4: bypass K=40
    src_q.push_back('{d:8'h5a, sop:0, eop:0, idx:8'd9, en:1});  // R12 stray beat
    add_pkt(0, 1, 2, 1);        // R6: index 0 -> K=40
    add_pkt(200, 0, 5, 4);      // R6: index 200 -> K=40
    add_pkt(60, 1, 61, -1);     // R5: K=512, no eop
    add_pkt(61, 0, 66, 65);     // R5: K=528 bypass
    drain();

    // Phase B: random gaps and back-pressure
    rnd_mode = 1;
    add_pkt(92, 1, 125, 124);   // R5: K=1024
    add_pkt(93, 1, 129, 128);   // R5: K=1056
    add_pkt(10, 1, 3, 2);       // R11: K=112 ended early after 3 bytes
    add_pkt(124, 0, 256, 255);  // R5: K=2048 bypass
    add_pkt(125, 1, 261, 260);  // R5: K=2112
    add_pkt(20, 0, 4, 3);       // R11: early end in bypass
    add_pkt(188, 1, 765, 764);  // R5: K=6144
    add_pkt(5, 1, 6, 5);        // R7: junk idx/en on later beats
    drain();

    if (cycles >= WATCHDOG) check(0, "R9", cycles, WATCHDOG);  // watchdog
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule